// File: doc/BRIEF.md
# Instruction Decoder Steering Stage

This stage sits between instruction predecode and the decoders. Each cycle it looks at a small window of instructions, already split at instruction boundaries. For each one it sees a valid flag, the register-extension bit taken from an optional REX prefix, and the primary opcode byte. It then hands the instructions, strictly in window order, to one complex decoder and to a set of simple decoders. The choice of decoder depends on the opcode byte alone. If any form of an opcode expands to several fused-domain micro-ops, the whole opcode goes to the complex decoder. That includes forms that really produce a single micro-op.

The short-form pop carries a register code in the low three bits of its opcode. Code 100 is shared by the stack pointer and by extended register 12; the REX extension bit tells them apart. Popping the stack pointer is a multi-micro-op operation, so every pop with code 100 is sent to the complex decoder. Popping extended register 12 still yields only one micro-op. The sign-extend-accumulator opcodes behave the same way: they go to the complex decoder and produce one micro-op. For the instruction it takes, the complex decoder reports how many micro-ops it produces.

The assignment is registered. Each cycle the block reports how many leading window entries were consumed. The upstream stage shifts the window by that amount.

Top module: `decode_steer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the outputs report no consumed instructions (`take_cnt` = 0) and no valid decoder assignment (`cx_vld` = 0, `sd_vld` = 0).
- R2: A short-form pop (opcodes 0x58 to 0x5F) whose low three opcode bits are not 100 goes to a simple decoder, whatever the extension bit is.
- R3: Opcode 0x5C with extension bit 0 (pop of the stack pointer) goes to the complex decoder, and `cx_uops` reports 3.
- R4: Opcode 0x5C with extension bit 1 (pop of extended register 12) goes to the complex decoder, and `cx_uops` reports 1.
- R5: Opcodes 0x98 and 0x99 (sign-extend accumulator) go to the complex decoder, and `cx_uops` reports 1.
- R6: At most one instruction per cycle reaches the complex decoder. Assignment stops at the second complex-class instruction in the window. Neither that instruction nor anything after it is consumed.
- R7: At most three instructions per cycle reach simple decoders. Simple-class instructions fill simple decoders 0, 1, 2 in window order, and a fourth simple-class instruction stops assignment. In `sd_slot`, decoder k uses bits [2k+1:2k].
- R8: Assignment stops at the first window entry whose valid bit is 0. An empty window consumes nothing.
- R9: The assignment for a window appears on the outputs one clock edge after that window is sampled. The outputs keep their previous values until that edge.
- R10: Any opcode outside the complex set {0x5C, 0x98, 0x99} is simple-class, for example 0x01, 0x8B and 0xC3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_vld | input | N | Valid flag per window entry, entry 0 oldest |
| win_rexb | input | N | REX register-extension bit per entry (0 without prefix) |
| win_op | input | 8*N | Primary opcode byte, entry i at bits [8i+7:8i] |
| take_cnt | output | clog2(N+1) | Number of leading window entries consumed |
| cx_vld | output | 1 | Complex decoder receives an instruction |
| cx_slot | output | clog2(N) | Window entry sent to the complex decoder |
| cx_uops | output | clog2(CX_POPSP_UOPS+1) | Micro-op count from the complex decoder |
| sd_vld | output | NS | Per simple decoder, an instruction is assigned |
| sd_slot | output | NS*clog2(N) | Window entry per simple decoder |

## Verification
Three windows check the steering rules:
- A window of pops that avoid register code 100, with mixed extension bits, shows that the extension bit does not change steering. It also hits the three-simple-decoder limit.
- Windows that place opcode 0x5C with each extension value among simple pops show that steering follows the opcode, while the micro-op count follows the extension bit.
- Windows with two complex-class opcodes in a row, or with a sign-extend opcode between ordinary ones, separate the "stop at the second complex" rule from the in-order filling of the simple decoders.

Two more kinds of window check the edges:
- Windows with a gap in the valid bits, or no valid entries, check that assignment stops at the first gap.
- A check just before the clock edge checks the single register stage.

// File: rtl/decode_steer.sv
module decode_steer #(
  parameter int N             = 4,
  parameter int NS            = 3,
  parameter int CX_POPSP_UOPS = 3,
  localparam int SW = $clog2(N),
  localparam int CW = $clog2(N + 1),
  localparam int UW = $clog2(CX_POPSP_UOPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     win_vld,
  input  logic [N-1:0]     win_rexb,
  input  logic [8*N-1:0]   win_op,
  output logic [CW-1:0]    take_cnt,
  output logic             cx_vld,
  output logic [SW-1:0]    cx_slot,
  output logic [UW-1:0]    cx_uops,
  output logic [NS-1:0]    sd_vld,
  output logic [NS*SW-1:0] sd_slot
);

  localparam logic [7:0] POP_BASE = 8'h58;
  localparam logic [7:0] POP_SP   = POP_BASE + 8'd4;
  localparam logic [7:0] SX_WORD  = 8'h98;
  localparam logic [7:0] SX_DBL   = 8'h99;

  function automatic logic op_complex(input logic [7:0] op);
    return (op == POP_SP) || (op == SX_WORD) || (op == SX_DBL);
  endfunction

  function automatic logic [UW-1:0] op_uops(input logic [7:0] op, input logic rexb);
    if (op == POP_SP && !rexb) return UW'(CX_POPSP_UOPS);
    return UW'(1);
  endfunction

  logic [CW-1:0]    cnt_n;
  logic             cxv_n;
  logic [SW-1:0]    cxs_n;
  logic [UW-1:0]    cxu_n;
  logic [NS-1:0]    sdv_n;
  logic [NS*SW-1:0] sds_n;

  always_comb begin
    logic stop;
    int   ns;
    stop  = 1'b0;
    ns    = 0;
    cnt_n = '0;
    cxv_n = 1'b0;
    cxs_n = '0;
    cxu_n = '0;
    sdv_n = '0;
    sds_n = '0;
    for (int i = 0; i < N; i++) begin
      logic [7:0] op;
      op = win_op[8*i +: 8];
      if (!stop) begin
        if (!win_vld[i]) begin
          stop = 1'b1;
        end else if (op_complex(op)) begin
          if (cxv_n) begin
            stop = 1'b1;
          end else begin
            cxv_n = 1'b1;
            cxs_n = SW'(i);
            cxu_n = op_uops(op, win_rexb[i]);
            cnt_n = cnt_n + CW'(1);
          end
        end else if (ns == NS) begin
          stop = 1'b1;
        end else begin
          sdv_n[ns]          = 1'b1;
          sds_n[ns*SW +: SW] = SW'(i);
          ns                 = ns + 1;
          cnt_n              = cnt_n + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_cnt <= '0;
      cx_vld   <= 1'b0;
      cx_slot  <= '0;
      cx_uops  <= '0;
      sd_vld   <= '0;
      sd_slot  <= '0;
    end else begin
      take_cnt <= cnt_n;
      cx_vld   <= cxv_n;
      cx_slot  <= cxs_n;
      cx_uops  <= cxu_n;
      sd_vld   <= sdv_n;
      sd_slot  <= sds_n;
    end
  end

endmodule

// File: rtl/decode_steer_chk.sv
module decode_steer_chk #(
  parameter int N             = 4,
  parameter int NS            = 3,
  parameter int CX_POPSP_UOPS = 3,
  localparam int SW = $clog2(N),
  localparam int CW = $clog2(N + 1),
  localparam int UW = $clog2(CX_POPSP_UOPS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     win_vld,
  input logic [N-1:0]     win_rexb,
  input logic [8*N-1:0]   win_op,
  input logic [CW-1:0]    take_cnt,
  input logic             cx_vld,
  input logic [SW-1:0]    cx_slot,
  input logic [UW-1:0]    cx_uops,
  input logic [NS-1:0]    sd_vld,
  input logic [NS*SW-1:0] sd_slot
);

  logic was_rst;
  always_ff @(posedge clk) begin
    was_rst <= !rst_n;
    if (was_rst)
      a_r1_idle_after_reset: assert (take_cnt == '0 && !cx_vld && sd_vld == '0);
  end

  a_r2_pop_simple: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld[0] && win_op[7:3] == 5'b01011 && win_op[2:0] != 3'b100)
      |=> (sd_vld[0] && sd_slot[SW-1:0] == '0 && !(cx_vld && cx_slot == '0)));

  a_r3_popsp_complex: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld[0] && win_op[7:0] == 8'h5C && !win_rexb[0])
      |=> (cx_vld && cx_slot == '0 && cx_uops == UW'(CX_POPSP_UOPS)));

  a_r4_popr12_complex: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld[0] && win_op[7:0] == 8'h5C && win_rexb[0])
      |=> (cx_vld && cx_slot == '0 && cx_uops == UW'(1)));

  a_r5_signext_complex: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld[0] && (win_op[7:0] == 8'h98 || win_op[7:0] == 8'h99))
      |=> (cx_vld && cx_slot == '0 && cx_uops == UW'(1)));

  a_r7_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (32'(take_cnt) == $countones(sd_vld) + 32'(cx_vld)));

  a_r7_fill_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (((sd_vld + NS'(1)) & sd_vld) == '0));

  a_r8_empty_head: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld[0] |=> (take_cnt == '0 && !cx_vld && sd_vld == '0));

  a_r9_hold_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(win_vld) && $stable(win_rexb) && $stable(win_op))
      |=> $stable(take_cnt));

endmodule

bind decode_steer decode_steer_chk #(.N(N), .NS(NS), .CX_POPSP_UOPS(CX_POPSP_UOPS)) u_chk (.*);

// File: tb/decode_steer_tb.sv
module decode_steer_tb;
  localparam int N = 4;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  win_vld = '0;
  logic [N-1:0]  win_rexb = '0;
  logic [8*N-1:0] win_op = '0;
  logic [2:0]    take_cnt;
  logic          cx_vld;
  logic [1:0]    cx_slot;
  logic [1:0]    cx_uops;
  logic [NS-1:0] sd_vld;
  logic [5:0]    sd_slot;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  decode_steer u_dut (
    .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_rexb(win_rexb), .win_op(win_op),
    .take_cnt(take_cnt), .cx_vld(cx_vld), .cx_slot(cx_slot), .cx_uops(cx_uops),
    .sd_vld(sd_vld), .sd_slot(sd_slot)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] v, input logic [3:0] rb,
                       input logic [7:0] o0, o1, o2, o3);
    @(negedge clk);
    win_vld = v; win_rexb = rb; win_op = {o3, o2, o1, o0};
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input int cnt, input int cv, input int cs,
                            input int cu, input int sv, input int ss);
    chk(req, "take_cnt", int'(take_cnt), cnt);
    chk(req, "cx_vld", int'(cx_vld), cv);
    if (cv != 0) begin
      chk(req, "cx_slot", int'(cx_slot), cs);
      chk(req, "cx_uops", int'(cx_uops), cu);
    end
    chk(req, "sd_vld", int'(sd_vld), sv);
    chk(req, "sd_slot", int'(sd_slot & {{2{sd_vld[2]}}, {2{sd_vld[1]}}, {2{sd_vld[0]}}}), ss);
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_out("R1", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_plain_pops;
    apply(4'b1111, 4'b1010, 8'h58, 8'h59, 8'h5D, 8'h5F);
    expect_out("R2", 3, 0, 0, 0, 3'b111, {2'd2, 2'd1, 2'd0});
    apply(4'b0011, 4'b0011, 8'h5B, 8'h5E, 8'h00, 8'h00);
    expect_out("R2", 2, 0, 0, 0, 3'b011, {2'd0, 2'd1, 2'd0});
  endtask

  task automatic t_pop_sp;
    apply(4'b1111, 4'b0000, 8'h5C, 8'h58, 8'h59, 8'h5A);
    expect_out("R3", 4, 1, 0, 3, 3'b111, {2'd3, 2'd2, 2'd1});
  endtask

  task automatic t_pop_r12;
    apply(4'b1111, 4'b0010, 8'h58, 8'h5C, 8'h5C, 8'h59);
    expect_out("R4", 2, 1, 1, 1, 3'b001, {2'd0, 2'd0, 2'd0});
  endtask

  task automatic t_signext;
    apply(4'b1111, 4'b0000, 8'h99, 8'h98, 8'h90, 8'h90);
    expect_out("R6", 1, 1, 0, 1, 3'b000, 0);
    apply(4'b1111, 4'b0000, 8'h90, 8'h98, 8'h90, 8'h90);
    expect_out("R5", 4, 1, 1, 1, 3'b111, {2'd3, 2'd2, 2'd0});
  endtask

  task automatic t_second_complex;
    apply(4'b1111, 4'b0001, 8'h5C, 8'h01, 8'h99, 8'h01);
    expect_out("R6", 2, 1, 0, 1, 3'b001, {2'd0, 2'd0, 2'd1});
  endtask

  task automatic t_other_ops;
    apply(4'b1111, 4'b0000, 8'h01, 8'h8B, 8'hC3, 8'h5C);
    expect_out("R10", 4, 1, 3, 3, 3'b111, {2'd2, 2'd1, 2'd0});
    apply(4'b1111, 4'b1111, 8'h8B, 8'hC3, 8'h01, 8'h03);
    expect_out("R7", 3, 0, 0, 0, 3'b111, {2'd2, 2'd1, 2'd0});
  endtask

  task automatic t_gaps;
    apply(4'b1101, 4'b0000, 8'h58, 8'h99, 8'h59, 8'h5A);
    expect_out("R8", 1, 0, 0, 0, 3'b001, {2'd0, 2'd0, 2'd0});
    apply(4'b1110, 4'b0000, 8'h5C, 8'h58, 8'h59, 8'h5A);
    expect_out("R8", 0, 0, 0, 0, 3'b000, 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    win_vld = 4'b0001; win_rexb = 4'b0000; win_op = {8'h00, 8'h00, 8'h00, 8'h5C};
    #1;
    chk("R9", "cx_vld before edge", int'(cx_vld), 0);
    chk("R9", "take_cnt before edge", int'(take_cnt), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "cx_vld after edge", int'(cx_vld), 1);
    chk("R9", "cx_uops after edge", int'(cx_uops), 3);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_plain_pops();
        t_pop_sp();
        t_pop_r12();
        t_signext();
        t_second_complex();
        t_other_ops();
        t_gaps();
        t_latency();
      end
      begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule